// File: doc/BRIEF.md
# UART Receive Byte Buffer

This block sits between a UART's receive deserialiser and the register interface. It buffers received bytes in a 16-entry first-in first-out store. It raises a trigger flag once a programmable fill level is reached, and it flags overrun when a byte arrives with no room for it. A received line break is stored as a zero byte. A character-timeout timer reports data that has been left unread for four frame times, and the frame length follows the configured character format. When the buffer is disabled, the block falls back to a single holding register.

Software controls the block through a control-register write strobe and reads bytes with a read strobe. A status-read strobe acknowledges the error flags. The receiver supplies a byte strobe, a break strobe and a one-per-bit-period tick. A cycle that carries a control write ignores the receive and read strobes.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, the control value is 0 (single-register mode), and data-ready, break, overrun, count, trigger and timeout are all 0.
- R2: A control write keeps only bits 7, 6, 3 and 0 of the written value (`ctrl_o` = value AND 0xC9). Bit 0 selects buffered mode. Bits 1 and 2 are one-shot receive and transmit resets and are never stored.
- R3: In buffered mode, bytes leave in arrival order. `rd_data_o` shows the oldest held byte, or 0 when the buffer is empty. `rd_i` removes one byte. `count_o` gives the number of bytes held, from 0 to 16.
- R4: In buffered mode, `trig_o` is high when count is at least the level that control bits 7:6 select: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R5: A byte that arrives while 16 bytes are held and no read occurs is discarded. The stored bytes stay unchanged, count stays 16 and overrun is set.
- R6: A byte that arrives in the same cycle as a read leaves the count unchanged. Both operations complete, even when the buffer is full, and no overrun occurs.
- R7: A break strobe stores the byte 0x00 and sets both break and data-ready.
- R8: Removing the last held byte clears data-ready and break. A status read clears overrun and break, but a flag being set in the same cycle wins.
- R9: A control write that changes bit 0 flushes the receive buffer, which clears count, data-ready, break and timeout, and pulses `tx_flush_o` in the following cycle. Bit 1 alone flushes the receive buffer. Bit 2 alone only pulses `tx_flush_o`.
- R10: In buffered mode with data held, `timeout_o` rises at the edge of the 4×F-th bit tick after the last push or read. F = 1 + (5 + cfg[1:0]) + cfg[3] + (cfg[2] ? 2 : 1), where cfg is `frame_cfg_i`.
- R11: A read clears a pending timeout and restarts the timer if data remains. A push restarts the timer but does not clear a pending timeout.
- R12: In single-register mode, a byte that arrives while data-ready is set overwrites the holding register and sets overrun. A read clears data-ready. `trig_o` follows data-ready, and count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write value |
| frame_cfg_i | input | 4 | Character format: [1:0] data bits minus 5, [2] two stop bits, [3] parity present |
| bit_tick_i | input | 1 | One pulse per bit period |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Break detected strobe |
| rd_i | input | 1 | Data read strobe |
| status_rd_i | input | 1 | Status read strobe, clears overrun and break |
| ctrl_o | output | 8 | Retained control bits |
| rd_data_o | output | 8 | Byte at the head of the buffer |
| data_ready_o | output | 1 | Data available |
| break_o | output | 1 | Break received |
| overrun_o | output | 1 | Byte lost |
| count_o | output | 5 | Bytes held in buffered mode |
| trig_o | output | 1 | Trigger level reached |
| timeout_o | output | 1 | Character timeout pending |
| tx_flush_o | output | 1 | One-cycle request to flush the transmit side |

## Verification
A corrupted read or write pointer shows up on the first read after the fault, as a byte out of order or a stale byte on `rd_data_o`. A count that drifts during simultaneous push and read appears at once on `count_o` and on the trigger flag. It also appears later as data-ready staying high, or dropping, at the wrong read. A timer that reloads at the wrong moment shows as `timeout_o` rising one or more ticks early or late. For that reason the bench samples both sides of the exact tick for two frame formats. A missed flush or a missed clear shows as a flag that stays high past the control write or the read that should have cleared it.

// File: rtl/rx_buf_pkg.sv
package rx_buf_pkg;
  localparam logic [7:0] CTRL_KEEP = 8'hC9;
  localparam int EN_BIT    = 0;
  localparam int RXRST_BIT = 1;
  localparam int TXRST_BIT = 2;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // start + data + parity + stop
  function automatic logic [3:0] frame_bits(input logic [3:0] cfg);
    return 4'd1 + (4'd5 + {2'b00, cfg[1:0]}) + {3'b000, cfg[3]} + (cfg[2] ? 4'd2 : 4'd1);
  endfunction
endpackage

// File: rtl/rx_buf_store.sv
module rx_buf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
  logic [CW-1:0] cnt_q;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_q + PW'(1);
      assign rd_nxt = rd_q + PW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
      assign rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_nxt;
      if (pop_i)  rd_q <= rd_nxt;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= din_i;
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_push_pop_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_buf_timer.sv
module rx_buf_timer #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          active_i,
  input  logic          restart_i,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          pending_o
);
  logic [TW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (clr_i) pend_q <= 1'b0;
      if (restart_i || !active_i) begin
        cnt_q <= '0;
      end else if (tick_i && !pend_q) begin
        if (cnt_q == limit_i - TW'(1)) begin
          cnt_q  <= '0;
          pend_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + TW'(1);
        end
      end
    end
  end

  assign pending_o = pend_q;

  assert_pending_on_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(tick_i) && $past(active_i));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rx_buf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int TO_CHARS = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [7:0]    ctrl_wdata_i,
  input  logic [3:0]    frame_cfg_i,
  input  logic          bit_tick_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          rx_break_i,
  input  logic          rd_i,
  input  logic          status_rd_i,
  output logic [7:0]    ctrl_o,
  output logic [DW-1:0] rd_data_o,
  output logic          data_ready_o,
  output logic          break_o,
  output logic          overrun_o,
  output logic [CW-1:0] count_o,
  output logic          trig_o,
  output logic          timeout_o,
  output logic          tx_flush_o
);
  localparam int TW = $clog2(TO_CHARS * 12 + 1);

  logic [7:0]    ctrl_q;
  logic          fifo_en, en_chg, flush_rx;
  logic          push_req, push_acc, pop;
  logic [DW-1:0] push_byte, head;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hold_q;
  logic          hold_vld_q, brk_q, ovr_q, txf_q;
  logic          ovr_set, brk_clr_last;
  logic [TW-1:0] to_limit;

  assign fifo_en   = ctrl_q[EN_BIT];
  assign en_chg    = ctrl_we_i && (ctrl_wdata_i[EN_BIT] != ctrl_q[EN_BIT]);
  assign flush_rx  = en_chg || (ctrl_we_i && ctrl_wdata_i[RXRST_BIT]);
  assign push_req  = (rx_valid_i || rx_break_i) && !ctrl_we_i;
  assign push_byte = rx_break_i ? '0 : rx_byte_i;
  assign pop       = fifo_en && rd_i && (cnt != '0) && !ctrl_we_i;
  assign push_acc  = fifo_en && push_req && ((cnt != CW'(DEPTH)) || pop);

  assign ovr_set = fifo_en ? (push_req && !push_acc)
                           : (push_req && hold_vld_q && !rd_i);
  assign brk_clr_last = fifo_en ? (pop && (cnt == CW'(1)) && !push_acc)
                                : (rd_i && !push_req && !ctrl_we_i);

  rx_buf_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_rx),
    .push_i  (push_acc),
    .pop_i   (pop),
    .din_i   (push_byte),
    .head_o  (head),
    .count_o (cnt)
  );

  assign to_limit = TW'(frame_bits(frame_cfg_i)) * TW'(TO_CHARS);

  rx_buf_timer #(.TW(TW)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (bit_tick_i),
    .active_i  (fifo_en && (cnt != '0)),
    .restart_i (push_acc || pop || flush_rx),
    .clr_i     (pop || flush_rx),
    .limit_i   (to_limit),
    .pending_o (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      txf_q  <= 1'b0;
    end else begin
      txf_q <= en_chg || (ctrl_we_i && ctrl_wdata_i[TXRST_BIT]);
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i & CTRL_KEEP;
    end
  end

  // single-register mode holding path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (flush_rx) begin
      hold_vld_q <= 1'b0;
    end else if (!fifo_en) begin
      if (push_req) begin
        hold_q     <= push_byte;
        hold_vld_q <= 1'b1;
      end else if (rd_i && !ctrl_we_i) begin
        hold_vld_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (rx_break_i && !ctrl_we_i)            brk_q <= 1'b1;
      else if (flush_rx || status_rd_i || brk_clr_last) brk_q <= 1'b0;
      if (ovr_set)          ovr_q <= 1'b1;
      else if (status_rd_i) ovr_q <= 1'b0;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign count_o      = cnt;
  assign data_ready_o = fifo_en ? (cnt != '0) : hold_vld_q;
  assign rd_data_o    = fifo_en ? ((cnt != '0) ? head : '0) : hold_q;
  assign trig_o       = fifo_en ? (int'(cnt) >= int'(trig_level(ctrl_q[7:6]))) : hold_vld_q;
  assign break_o      = brk_q;
  assign overrun_o    = ovr_q;
  assign tx_flush_o   = txf_q;

  assert_full_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en && cnt == CW'(DEPTH) && push_req && !rd_i) |=> (overrun_o && count_o == CW'(DEPTH)));
  assert_read_clears_timeout_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en && rd_i && cnt != '0 && !ctrl_we_i) |=> !timeout_o);
  assert_timeout_has_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> data_ready_o);
  assert_break_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_break_i && !ctrl_we_i && !(fifo_en && cnt == CW'(DEPTH))) |=> (break_o && data_ready_o));
  assert_hold_overrun_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en && hold_vld_q && push_req && !rd_i) |=> overrun_o);
  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_rx |=> (count_o == '0 && !data_ready_o && !timeout_o));
endmodule

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic [3:0] frame_cfg_i = 4'b0011;
  logic       bit_tick_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic       rx_break_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       status_rd_i = 1'b0;
  logic [7:0] ctrl_o, rd_data_o;
  logic       data_ready_o, break_o, overrun_o, trig_o, timeout_o, tx_flush_o;
  logic [4:0] count_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;

  uart_rx_buffer i_uart_rx_buffer (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .frame_cfg_i, .bit_tick_i,
    .rx_valid_i, .rx_byte_i, .rx_break_i, .rd_i, .status_rd_i,
    .ctrl_o, .rd_data_o, .data_ready_o, .break_o, .overrun_o, .count_o,
    .trig_o, .timeout_o, .tx_flush_o
  );

  // op[9:8]: 0 push, 1 read expecting data, 2 expect count
  localparam logic [9:0] VEC [10] = '{
    {2'd0, 8'h11}, {2'd0, 8'h22}, {2'd0, 8'h33}, {2'd2, 8'd3},
    {2'd1, 8'h11}, {2'd0, 8'h44}, {2'd1, 8'h22}, {2'd1, 8'h33},
    {2'd1, 8'h44}, {2'd2, 8'd0}
  };

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid_i = 1'b1; rx_byte_i = b;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic brk();
    rx_break_i = 1'b1;
    @(negedge clk_i);
    rx_break_i = 1'b0;
  endtask

  task automatic rd();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    chk(req, rd_data_o, exp);
    rd();
  endtask

  task automatic wctrl(input logic [7:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic srd();
    status_rd_i = 1'b1;
    @(negedge clk_i);
    status_rd_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick_i = 1'b1;
      @(negedge clk_i);
      bit_tick_i = 1'b0;
    end
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 ctrl", ctrl_o, 8'h00);
    chk("R1 flags", {data_ready_o, break_o, overrun_o, trig_o, timeout_o}, 5'b0);
    chk("R1 count", count_o, 5'd0);

    // R12 single-register mode
    push(8'h41);
    chk("R12 ready", data_ready_o, 1'b1);
    chk("R12 data", rd_data_o, 8'h41);
    chk("R12 trig", trig_o, 1'b1);
    push(8'h42);
    chk("R12 overrun", overrun_o, 1'b1);
    chk("R12 overwrite", rd_data_o, 8'h42);
    chk("R12 count", count_o, 5'd0);
    rd();
    chk("R12 read clears", data_ready_o, 1'b0);
    srd();
    chk("R8 status clears overrun", overrun_o, 1'b0);

    // R2 / R9 control write
    wctrl(8'hFF);
    chk("R2 retained", ctrl_o, 8'hC9);
    chk("R9 tx flush pulse", tx_flush_o, 1'b1);
    idle(1);
    chk("R9 tx flush single", tx_flush_o, 1'b0);
    wctrl(8'h01);
    chk("R9 no flush w/o change", tx_flush_o, 1'b0);

    // R3 table walk
    foreach (VEC[i]) begin
      case (VEC[i][9:8])
        2'd0: push(VEC[i][7:0]);
        2'd1: rd_chk("R3 order", VEC[i][7:0]);
        default: chk("R3 count", count_o, VEC[i][4:0]);
      endcase
    end
    chk("R8 empty ready", data_ready_o, 1'b0);
    chk("R3 empty data", rd_data_o, 8'h00);

    // R4 trigger levels, R5 overrun, R6 push+read
    wctrl(8'h43);
    chk("R9 rx reset count", count_o, 5'd0);
    chk("R2 ctrl 43", ctrl_o, 8'h41);
    for (int i = 1; i <= 3; i++) push(8'(i));
    chk("R4 below 4", trig_o, 1'b0);
    push(8'd4);
    chk("R4 at 4", trig_o, 1'b1);
    wctrl(8'h81);
    chk("R4 below 8", trig_o, 1'b0);
    wctrl(8'hC1);
    for (int i = 5; i <= 13; i++) push(8'(i));
    chk("R4 below 14", trig_o, 1'b0);
    push(8'd14);
    chk("R4 at 14", trig_o, 1'b1);
    push(8'd15);
    push(8'd16);
    chk("R5 full count", count_o, 5'd16);
    chk("R5 no overrun yet", overrun_o, 1'b0);
    push(8'hEE);
    chk("R5 overrun", overrun_o, 1'b1);
    chk("R5 count kept", count_o, 5'd16);
    chk("R5 head kept", rd_data_o, 8'd1);
    srd();
    rx_valid_i = 1'b1; rx_byte_i = 8'h99; rd_i = 1'b1;
    @(negedge clk_i);
    rx_valid_i = 1'b0; rd_i = 1'b0;
    chk("R6 count", count_o, 5'd16);
    chk("R6 no overrun", overrun_o, 1'b0);
    for (int i = 2; i <= 16; i++) rd_chk("R5 contents", 8'(i));
    rd_chk("R6 appended", 8'h99);
    chk("R8 drained", data_ready_o, 1'b0);

    // R7 / R8 break in buffered mode
    push(8'h5A);
    brk();
    chk("R7 count", count_o, 5'd2);
    chk("R7 break", break_o, 1'b1);
    rd_chk("R7 first", 8'h5A);
    chk("R8 break held", break_o, 1'b1);
    rd_chk("R7 zero byte", 8'h00);
    chk("R8 last clears", {data_ready_o, break_o}, 2'b00);

    // R10 / R11 timeout, 8N1 -> 40 ticks
    frame_cfg_i = 4'b0011;
    push(8'h77);
    tick(39);
    chk("R10 early", timeout_o, 1'b0);
    tick(1);
    chk("R10 fires", timeout_o, 1'b1);
    push(8'h78);
    chk("R11 push keeps", timeout_o, 1'b1);
    rd();
    chk("R11 read clears", timeout_o, 1'b0);
    tick(39);
    chk("R11 restarted early", timeout_o, 1'b0);
    tick(1);
    chk("R11 restarted fires", timeout_o, 1'b1);
    // 5 data, parity, 2 stop -> 36 ticks
    frame_cfg_i = 4'b1100;
    rd();
    push(8'h10);
    tick(35);
    chk("R10 short frame early", timeout_o, 1'b0);
    tick(1);
    chk("R10 short frame fires", timeout_o, 1'b1);
    wctrl(8'hC3);
    chk("R9 rx reset clears timeout", {timeout_o, count_o}, 6'd0);
    chk("R9 rx reset no tx", tx_flush_o, 1'b0);
    wctrl(8'hC5);
    chk("R9 tx reset only", tx_flush_o, 1'b1);

    // R9 mode change flush
    push(8'h01);
    push(8'h02);
    wctrl(8'h00);
    chk("R9 mode flush", {count_o, data_ready_o}, 6'd0);
    chk("R9 mode ctrl", ctrl_o, 8'h00);
    chk("R9 mode tx flush", tx_flush_o, 1'b1);

    // R7 / R8 break in single-register mode
    push(8'h33);
    brk();
    chk("R7 hold break", {data_ready_o, break_o, rd_data_o}, {2'b11, 8'h00});
    rd();
    chk("R8 hold read clears", {data_ready_o, break_o}, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule